// File: doc/BRIEF.md
# Qualified Thresholded Event Counter

A single performance-monitoring counter. An event source presents, every clock, a small bus of per-cycle event counts for each of two hardware threads. A select register picks one event from that bus and says, through four qualifier bits, which thread and privilege-mode pairs may contribute to the count. A configuration register holds an enable bit, a compare bit, a complement bit and a 4-bit threshold. Each cycle the block turns the qualified event counts into an increment and adds it to a 40-bit count register.

With compare off, the increment is the sum of the qualified counts of both threads. With compare on, the sum, saturated at 15, is tested against the threshold and the counter adds one on every cycle where the test passes. The complement bit turns the test from "greater than" into "less than or equal". Threshold 15 with complement set can never fail, so this setting counts every cycle in which the monitoring logic has power. Software can load the count register at any time. The counter wraps to zero and flags the wrap with a one-cycle pulse.

Top module: `perf_event_counter`

## Requirements
- R1: The count changes through increments only while the enable bit (configuration bit 0) is 1. With enable 0, only a software load changes the count.
- R2: An event code of 0 in select bits [6:4] means no event, and codes above the number of events also mean no event. The count then does not advance in any mode, including compare mode with threshold 15 and complement 1.
- R3: With compare (configuration bit 1) at 1 and complement (bit 2) at 0, the count advances by exactly 1 in cycles where the saturated qualified sum is greater than the threshold (bits [6:3]), and by 0 otherwise.
- R4: With compare 1 and complement 1, the count advances by exactly 1 in cycles where the saturated qualified sum is less than or equal to the threshold, and by 0 otherwise.
- R5: With compare 1, complement 1 and threshold 15, the count advances by 1 in every powered cycle, whatever the qualifier bits, privilege modes and per-thread halt flags are.
- R6: Select bit 0 admits thread 0 in kernel mode, bit 1 thread 0 in user mode, bit 2 thread 1 in kernel mode and bit 3 thread 1 in user mode (privilege input 1 is kernel). A thread's event count adds to the sum only when the bit for its current mode is set.
- R7: The event count of a halted thread is not added to the sum.
- R8: The monitoring logic is unpowered, and nothing is counted, only in cycles where both threads are halted and the power-down flag is 1. With only one thread halted, or with the flag at 0, the cycle-count setting keeps counting.
- R9: With compare 0, the count advances by the sum of the qualified event counts of both threads, each 0 to 15.
- R10: The count is 40 bits wide and wraps modulo 2^40. In the cycle after an increment that wraps it, the overflow pulse is 1 for exactly one cycle.
- R11: A software load of the count takes priority over an increment in the same cycle. Writes to the select and configuration registers take effect from the following cycle.
- R12: A synchronous active-low reset clears the count, the overflow pulse, the select register and all configuration fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_t0 | input | EVT_NUM*4 | Per-cycle counts of thread 0, event e in bits [4e+3:4e] |
| evt_t1 | input | EVT_NUM*4 | Per-cycle counts of thread 1, same layout |
| priv_t0 | input | 1 | Thread 0 mode, 1 = kernel, 0 = user |
| priv_t1 | input | 1 | Thread 1 mode, 1 = kernel, 0 = user |
| halt_t0 | input | 1 | Thread 0 halted |
| halt_t1 | input | 1 | Thread 1 halted |
| pwr_down | input | 1 | Package power-down request |
| sel_we | input | 1 | Load the select register |
| sel_wdata | input | CODE_W+4 | Qualifiers [3:0], event code [CODE_W+3:4] |
| cfg_we | input | 1 | Load the configuration register |
| cfg_wdata | input | 7 | Enable [0], compare [1], complement [2], threshold [6:3] |
| cnt_we | input | 1 | Load the count register |
| cnt_wdata | input | CNT_W | Value to load |
| cnt_q | output | CNT_W | Current count |
| ovf_pulse | output | 1 | One-cycle wrap indication |

## Verification
A software load of the count and an increment can fall in the same cycle. So can a configuration write and the last cycle that the old configuration still governs. The bench loads the count while events are flowing and expects exactly the loaded value with no overflow pulse. It also rewrites the configuration in a cycle that still counts and expects the old setting in that cycle and the new one from the next. Random traffic repeats both collisions many times against a bench-side model of every requirement.

// File: rtl/perf_cnt_pkg.sv
// Package: shared widths and the configuration layout of the event counter.
// Assumes a 4-bit threshold and 4-bit per-thread event counts.
package perf_cnt_pkg;
    localparam int THR_W  = 4;                 // threshold and event count width
    localparam int QUAL_W = 4;                 // thread/mode qualifier bits
    localparam int INC_W  = THR_W + 1;         // sum of two thread counts
    localparam int CFG_W  = THR_W + 3;

    // Packed so that en is bit 0, cmp bit 1, comp bit 2, thr [6:3].
    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             comp;
        logic             cmp;
        logic             en;
    } cfg_t;
endpackage

// File: rtl/perf_qualify.sv
// Module: picks the selected event count of one thread and masks it by the
// thread's mode qualifier and halt flag. Assumes code 0 and codes above
// EVT_NUM are "no event" and give 0.
module perf_qualify
    import perf_cnt_pkg::*;
#(
    parameter int EVT_NUM = 4,
    parameter int CODE_W  = 3
) (
    input  logic [EVT_NUM*THR_W-1:0] evt,
    input  logic [CODE_W-1:0]        code,
    input  logic                     ok_kern,
    input  logic                     ok_user,
    input  logic                     priv_kern,
    input  logic                     halted,
    output logic [THR_W-1:0]         val
);
    logic [THR_W-1:0] picked;
    logic             mode_ok;

    // Event multiplexer: choose the count matching the select code.
    always_comb begin
        picked = '0;
        for (int e = 0; e < EVT_NUM; e++) begin
            if (code == CODE_W'(e + 1)) picked = evt[e*THR_W +: THR_W];
        end
    end

    // Qualification: mode bit for the current privilege, thread not halted.
    always_comb begin
        mode_ok = priv_kern ? ok_kern : ok_user;
        val     = (mode_ok && !halted) ? picked : '0;
    end
endmodule

// File: rtl/perf_threshold.sv
// Module: turns two qualified thread counts into the per-cycle increment,
// either as a raw sum or as a 0/1 threshold condition. Assumes the caller
// supplies the power state and whether the event code is valid.
module perf_threshold
    import perf_cnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic             code_ok,
    input  logic             powered,
    input  logic [THR_W-1:0] v0,
    input  logic [THR_W-1:0] v1,
    output logic [INC_W-1:0] inc
);
    localparam logic [THR_W-1:0] SAT_MAX = {THR_W{1'b1}};

    logic [INC_W-1:0] sum;
    logic [THR_W-1:0] sat;
    logic             cond;
    logic             gate;

    // Sum and saturate the qualified counts for the comparison.
    always_comb begin
        sum = INC_W'(v0) + INC_W'(v1);
        sat = (sum > INC_W'(SAT_MAX)) ? SAT_MAX : sum[THR_W-1:0];
    end

    // Threshold test, inverted to "less or equal" by the complement bit.
    always_comb cond = cfg.comp ? (sat <= cfg.thr) : (sat > cfg.thr);

    // Increment: gated by enable, event validity and power.
    always_comb begin
        gate = cfg.en && code_ok && powered;
        if (!gate)        inc = '0;
        else if (cfg.cmp) inc = INC_W'(cond);
        else              inc = sum;
    end

    p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.cmp |-> inc <= INC_W'(1))
        else $error("compare mode stepped by more than one");
    p_null_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ok |-> inc == '0)
        else $error("no-event code produced an increment");
    p_unpowered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !powered |-> inc == '0)
        else $error("counted while unpowered");
    p_cycle_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cfg.cmp && cfg.comp && cfg.thr == SAT_MAX && code_ok && powered) |-> inc == INC_W'(1))
        else $error("cycle-count setting missed a powered cycle");
endmodule

// File: rtl/perf_accum.sv
// Module: the wide count register. A software load wins over the increment;
// a wrap raises a one-cycle pulse. Assumes inc is already gated.
module perf_accum
    import perf_cnt_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W:0] nxt;

    // Next value with carry out of the top bit.
    always_comb nxt = {1'b0, cnt} + (CNT_W + 1)'(inc);

    // Count register and wrap pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            wrap <= 1'b0;
        end else if (ld) begin
            cnt  <= ld_val;
            wrap <= 1'b0;
        end else begin
            cnt  <= nxt[CNT_W-1:0];
            wrap <= nxt[CNT_W];
        end
    end

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld)) |-> (cnt == $past(ld_val) && !wrap))
        else $error("software load lost to increment");
    p_wrap_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (cnt < $past(cnt)))
        else $error("overflow pulse without a wrap");
    p_wrap_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !wrap || (cnt < $past(cnt)))
        else $error("overflow pulse held without a second wrap");
endmodule

// File: rtl/perf_event_counter.sv
// Module: top of one qualified, thresholded performance counter. Holds the
// select and configuration registers, qualifies both threads, forms the
// increment and accumulates it. Assumes two threads and synchronous writes.
module perf_event_counter
    import perf_cnt_pkg::*;
#(
    parameter int CNT_W   = 40,
    parameter int EVT_NUM = 4,
    localparam int CODE_W = $clog2(EVT_NUM + 1),
    localparam int SEL_W  = CODE_W + QUAL_W,
    localparam int BUS_W  = EVT_NUM * THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] evt_t0,
    input  logic [BUS_W-1:0] evt_t1,
    input  logic             priv_t0,
    input  logic             priv_t1,
    input  logic             halt_t0,
    input  logic             halt_t1,
    input  logic             pwr_down,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_pulse
);
    localparam int NTHR = 2;

    cfg_t              cfg_q;
    logic [QUAL_W-1:0] qual_q;
    logic [CODE_W-1:0] code_q;
    logic              code_ok;
    logic              powered;
    logic [THR_W-1:0]  tval [NTHR];
    logic [BUS_W-1:0]  tevt [NTHR];
    logic [NTHR-1:0]   tpriv;
    logic [NTHR-1:0]   thalt;
    logic [INC_W-1:0]  inc;

    // Select and configuration registers, visible from the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            qual_q <= '0;
            code_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
            if (sel_we) {code_q, qual_q} <= sel_wdata;
        end
    end

    // Event code validity and power state of the monitoring logic.
    always_comb begin
        code_ok = (code_q != '0) && (code_q <= CODE_W'(EVT_NUM));
        powered = !(halt_t0 && halt_t1 && pwr_down);
    end

    // Per-thread input arrays for the generated qualifiers.
    always_comb begin
        tevt[0] = evt_t0;  tevt[1] = evt_t1;
        tpriv   = {priv_t1, priv_t0};
        thalt   = {halt_t1, halt_t0};
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        perf_qualify #(.EVT_NUM(EVT_NUM), .CODE_W(CODE_W)) u_qual (
            .evt      (tevt[t]),
            .code     (code_q),
            .ok_kern  (qual_q[2*t]),
            .ok_user  (qual_q[2*t+1]),
            .priv_kern(tpriv[t]),
            .halted   (thalt[t]),
            .val      (tval[t])
        );
    end

    perf_threshold u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg_q),
        .code_ok(code_ok),
        .powered(powered),
        .v0     (tval[0]),
        .v1     (tval[1]),
        .inc    (inc)
    );

    perf_accum #(.CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .ld    (cnt_we),
        .ld_val(cnt_wdata),
        .cnt   (cnt_q),
        .wrap  (ovf_pulse)
    );

    p_disabled_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en && !cnt_we) |=> $stable(cnt_q))
        else $error("count moved while disabled");
    p_halted_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_t0 && halt_t1 && !cfg_q.cmp && !cnt_we) |=> $stable(cnt_q))
        else $error("halted threads contributed events");
    p_reset_clear_r12: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && !ovf_pulse))
        else $error("reset did not clear the count");
endmodule

// File: tb/sim_perf_event_counter.sv
module sim_perf_event_counter;
    localparam int CNT_W = 40;
    localparam int EN    = 4;
    localparam int BW    = EN * 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [BW-1:0]    evt_t0, evt_t1;
    logic             priv_t0, priv_t1, halt_t0, halt_t1, pwr_down;
    logic             sel_we, cfg_we, cnt_we;
    logic [6:0]       sel_wdata, cfg_wdata;
    logic [CNT_W-1:0] cnt_wdata, cnt_q;
    logic             ovf_pulse;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Bench model of the software-visible state.
    logic [CNT_W-1:0] m_cnt;
    logic             m_ovf;
    logic             m_en, m_cmp, m_comp;
    logic [3:0]       m_thr, m_qual;
    logic [2:0]       m_code;

    perf_event_counter #(.CNT_W(CNT_W), .EVT_NUM(EN)) u0 (
        .clk, .rst_n, .evt_t0, .evt_t1, .priv_t0, .priv_t1, .halt_t0, .halt_t1,
        .pwr_down, .sel_we, .sel_wdata, .cfg_we, .cfg_wdata, .cnt_we, .cnt_wdata,
        .cnt_q, .ovf_pulse
    );

    always #10 clk = ~clk;

    function automatic int thr_val(logic [BW-1:0] ev, logic pk, logic hl, int t);
        int v;
        if (m_code == 0 || m_code > EN) return 0;
        v = int'(ev[(int'(m_code) - 1) * 4 +: 4]);
        if (hl) return 0;
        if (!m_qual[2*t + (pk ? 0 : 1)]) return 0;
        return v;
    endfunction

    function automatic int exp_inc();
        int s, sat;
        if (!m_en || m_code == 0 || m_code > EN) return 0;
        if (halt_t0 && halt_t1 && pwr_down) return 0;
        s = thr_val(evt_t0, priv_t0, halt_t0, 0) + thr_val(evt_t1, priv_t1, halt_t1, 1);
        if (!m_cmp) return s;
        sat = (s > 15) ? 15 : s;
        if (m_comp) return (sat <= int'(m_thr)) ? 1 : 0;
        return (sat > int'(m_thr)) ? 1 : 0;
    endfunction

    task automatic check(string req, logic [CNT_W-1:0] got, logic [CNT_W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One clock: update the model from the pre-edge inputs, then compare.
    task automatic tick(string req);
        logic [CNT_W:0] nx;
        nx = {1'b0, m_cnt} + (CNT_W + 1)'(exp_inc());
        if (!rst_n) begin
            m_cnt = '0; m_ovf = 0; m_en = 0; m_cmp = 0; m_comp = 0;
            m_thr = 0; m_qual = 0; m_code = 0;
        end else begin
            if (cnt_we) begin m_cnt = cnt_wdata; m_ovf = 0; end
            else begin m_cnt = nx[CNT_W-1:0]; m_ovf = nx[CNT_W]; end
            if (cfg_we) {m_thr, m_comp, m_cmp, m_en} = cfg_wdata;
            if (sel_we) {m_code, m_qual} = sel_wdata;
        end
        @(posedge clk); #1;
        sel_we = 0; cfg_we = 0; cnt_we = 0;
        check({req, " count"}, cnt_q, m_cnt);
        check({req, " pulse"}, CNT_W'(ovf_pulse), CNT_W'(m_ovf));
    endtask

    task automatic wr_cfg(logic en, logic cmp, logic comp, logic [3:0] thr);
        cfg_we = 1; cfg_wdata = {thr, comp, cmp, en};
    endtask
    task automatic wr_sel(logic [2:0] code, logic [3:0] q);
        sel_we = 1; sel_wdata = {code, q};
    endtask
    task automatic set_ev(int t0, int t1);
        evt_t0 = '0; evt_t1 = '0;
        evt_t0[4 +: 4] = 4'(t0); evt_t1[4 +: 4] = 4'(t1);   // event code 2
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] base;
        void'($urandom(32'd7531));
        rst_n = 0; sel_we = 0; cfg_we = 0; cnt_we = 0;
        sel_wdata = 0; cfg_wdata = 0; cnt_wdata = 0;
        priv_t0 = 0; priv_t1 = 0; halt_t0 = 0; halt_t1 = 0; pwr_down = 0;
        set_ev(5, 5);
        #1;
        tick("R12"); tick("R12");
        check("R12 reset count", cnt_q, '0);
        rst_n = 1;
        // R12: enable cleared by reset, select code 2 with all qualifiers
        wr_sel(3'd2, 4'hF); tick("R12");
        tick("R12"); check("R12 enable cleared", cnt_q, '0);

        // R1: enable 0 with events flowing
        wr_cfg(0, 0, 0, 0); tick("R1"); tick("R1");
        check("R1 disabled hold", cnt_q, '0);

        // R9: raw sum mode, 7 + 9 per cycle
        set_ev(7, 9); wr_cfg(1, 0, 0, 0); tick("R9");
        base = cnt_q; tick("R9");
        check("R9 sum", cnt_q, base + 16);

        // R6: only thread 0 user admitted
        wr_sel(3'd2, 4'b0010); set_ev(3, 5); tick("R6");
        base = cnt_q; tick("R6"); check("R6 t0 user", cnt_q, base + 3);
        priv_t0 = 1; base = cnt_q; tick("R6"); check("R6 t0 kernel blocked", cnt_q, base);
        wr_sel(3'd2, 4'b0100); priv_t1 = 1; tick("R6");
        base = cnt_q; tick("R6"); check("R6 t1 kernel", cnt_q, base + 5);
        priv_t0 = 0; priv_t1 = 0;

        // R7: halted thread masked
        wr_sel(3'd2, 4'hF); halt_t0 = 1; tick("R7");
        base = cnt_q; tick("R7"); check("R7 halted t0", cnt_q, base + 5);
        halt_t0 = 0;

        // R3: greater than threshold 4
        wr_cfg(1, 1, 0, 4'd4); set_ev(2, 2); tick("R3");
        base = cnt_q; tick("R3"); check("R3 equal not counted", cnt_q, base);
        set_ev(2, 3); base = cnt_q; tick("R3"); check("R3 above counted", cnt_q, base + 1);
        set_ev(15, 15); base = cnt_q; tick("R3"); check("R3 saturated one step", cnt_q, base + 1);

        // R4: complement, less or equal
        wr_cfg(1, 1, 1, 4'd4); set_ev(2, 2); tick("R4");
        base = cnt_q; tick("R4"); check("R4 equal counted", cnt_q, base + 1);
        set_ev(2, 3); base = cnt_q; tick("R4"); check("R4 above not counted", cnt_q, base);

        // R5: always-true setting ignores qualifiers and one halt
        wr_cfg(1, 1, 1, 4'd15); wr_sel(3'd2, 4'h0); set_ev(15, 15); halt_t1 = 1; tick("R5");
        base = cnt_q; tick("R5"); tick("R5"); check("R5 cycle count", cnt_q, base + 2);

        // R8: power gating needs both halts and the flag
        halt_t0 = 1; base = cnt_q; tick("R8"); check("R8 halted no flag", cnt_q, base + 1);
        pwr_down = 1; base = cnt_q; tick("R8"); check("R8 asleep", cnt_q, base);
        halt_t0 = 0; base = cnt_q; tick("R8"); check("R8 one awake", cnt_q, base + 1);
        halt_t1 = 0; pwr_down = 0;

        // R2: null event code in the cycle-count setting
        wr_sel(3'd0, 4'hF); tick("R2");
        base = cnt_q; tick("R2"); check("R2 null code", cnt_q, base);
        wr_sel(3'd7, 4'hF); tick("R2");
        base = cnt_q; tick("R2"); check("R2 out of range code", cnt_q, base);

        // R11: load beats increment; config write takes effect next cycle
        wr_sel(3'd2, 4'hF); wr_cfg(1, 0, 0, 0); set_ev(4, 4); tick("R11");
        cnt_we = 1; cnt_wdata = 40'd1000; tick("R11");
        check("R11 load wins", cnt_q, 40'd1000);
        wr_cfg(0, 0, 0, 0); tick("R11"); check("R11 old config this cycle", cnt_q, 40'd1008);
        tick("R11"); check("R11 new config next", cnt_q, 40'd1008);

        // R10: wrap with pulse
        wr_cfg(1, 0, 0, 0); set_ev(1, 2); cnt_we = 1; cnt_wdata = {CNT_W{1'b1}} - 1; tick("R10");
        tick("R10"); check("R10 wrapped", cnt_q, 40'd1);
        check("R10 pulse", CNT_W'(ovf_pulse), 1);
        tick("R10"); check("R10 pulse single", CNT_W'(ovf_pulse), 0);

        // Random traffic mixing every requirement (R6, R7, R8, R9, R3, R4, R11)
        for (int i = 0; i < 4000; i++) begin
            evt_t0 = BW'($urandom); evt_t1 = BW'($urandom);
            priv_t0 = 1'($urandom); priv_t1 = 1'($urandom);
            halt_t0 = ($urandom % 4) == 0; halt_t1 = ($urandom % 4) == 0;
            pwr_down = ($urandom % 3) == 0;
            if ($urandom % 30 == 0) begin sel_we = 1; sel_wdata = 7'($urandom); end
            if ($urandom % 30 == 0) begin
                cfg_we = 1; cfg_wdata = 7'($urandom);
                if ($urandom % 4 != 0) cfg_wdata[0] = 1'b1;
            end
            if ($urandom % 60 == 0) begin
                cnt_we = 1;
                cnt_wdata = ($urandom % 2) ? {CNT_W{1'b1}} - CNT_W'($urandom % 40) : CNT_W'($urandom);
            end
            tick("random R9");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule